// File: doc/BRIEF.md
# Decimating Rate Averager with Extended Output

This block takes a stream of 16-bit two's complement angular-rate samples and sums a window of 2^D consecutive accepted samples, where D is a 5-bit decimation setting. At the end of each window it publishes one result as two 16-bit words. The main word is the window sum divided by 2^D, rounded towards minus infinity. It uses the same LSB weight as a single input sample, so one LSB stands for 0.018275 deg/s and zero rate reads 0x0000. The extension word holds the D remainder bits that the division shifts out. They sit MSB-justified: the first of them is bit 15 and the last is bit 16-D. This keeps the extra precision gained from averaging.

Only cycles with the sample-valid input high count towards a window. A one-cycle result strobe marks each new result, and both words hold their value until the next one. If the decimation setting changes, the running window is abandoned and a new window starts. A small read decoder places the temperature word, the extension word and the main word at fixed addresses, so a register interface can read them.

Top module: `rate_decimator`

## Requirements
- R1: While reset is high and after it, before the first result, `res_valid` is 0 and `res_main`, `res_ext` read 0x0000.
- R2: A result is produced after every 2^D accepted samples (cycles with `smp_valid` high); `res_valid` is high for exactly the cycle after the clock edge that accepts the last sample of the window and is low otherwise.
- R3: `res_main` equals the two's complement window sum shifted arithmetically right by D, low 16 bits (floor of the mean).
- R4: `res_ext` carries the D bits shifted out of the sum, MSB-justified: for 1 ≤ D ≤ 16 the lowest of them is at bit 16-D and bits below it are 0; for D > 16 it carries the upper 16 of those bits.
- R5: With D = 0 every accepted sample appears unchanged on `res_main` one edge later and `res_ext` reads 0x0000.
- R6: `res_main` and `res_ext` change only on edges that raise a result, and both update on that same edge.
- R7: On any edge where `dec_sel` differs from the setting in use, the partial sum and count are discarded, a sample offered in that cycle is dropped, and no result is produced; the next accepted sample starts a new window with the new setting. The setting in use after reset is 0.
- R8: `rd_data` returns `temp_data` at address 0x02, `res_ext` at 0x04, `res_main` at 0x06 and 0x0000 at any other address, combinationally.
- R9: The sum cannot overflow: windows made entirely of 0x8000 or of 0x7FFF give exactly 0x8000 or 0x7FFF on `res_main` with `res_ext` 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 16 | Rate sample, two's complement |
| dec_sel | input | 5 | Decimation setting D, window of 2^D samples |
| temp_data | input | 16 | Temperature word for the read decoder |
| rd_addr | input | 8 | Read address |
| rd_data | output | 16 | Read data selected by rd_addr |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_main | output | 16 | Averaged rate, sample LSB weight |
| res_ext | output | 16 | MSB-justified extra precision bits |

## Verification
The hardest state to reach is a change of setting in the middle of a window while samples keep arriving with gaps. The partial sum must then vanish, the sample in the change cycle must be dropped, and the next window must count from zero. Random phases therefore change `dec_sel` at random points inside a window, with sample-valid gaps, and a reference model in the bench follows the same counting. Directed windows of all-minimum and all-maximum samples push the sum to its extremes, and a pass with D = 0 covers straight pass-through.

// File: rtl/dec_pkg.sv
package dec_pkg;
    localparam int SMP_W  = 16;
    localparam int DSEL_W = 5;
    localparam int MAX_D  = (1 << DSEL_W) - 1;
    localparam int CNT_W  = MAX_D;
    localparam int ACC_W  = SMP_W + MAX_D;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_TEMP = 8'h02;
    localparam logic [ADDR_W-1:0] ADDR_EXT  = 8'h04;
    localparam logic [ADDR_W-1:0] ADDR_MAIN = 8'h06;

    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        logic [SMP_W-1:0] main_w;
        logic [SMP_W-1:0] ext_w;
    } result_t;

    function automatic acc_t widen(input logic [SMP_W-1:0] s);
        return {{(ACC_W-SMP_W){s[SMP_W-1]}}, s};
    endfunction

    function automatic result_t split_sum(input acc_t sum, input logic [DSEL_W-1:0] d);
        logic signed [ACC_W+SMP_W-1:0] wide;
        result_t r;
        wide     = $signed({sum, {SMP_W{1'b0}}}) >>> d;
        r.main_w = wide[2*SMP_W-1:SMP_W];
        r.ext_w  = wide[SMP_W-1:0];
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] last_index(input logic [DSEL_W-1:0] d);
        return {CNT_W{1'b1}} >> (CNT_W - int'(d));
    endfunction
endpackage

// File: rtl/dec_window_ctrl.sv
module dec_window_ctrl
    import dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [DSEL_W-1:0] dec_sel,
    output logic              restart,
    output logic              accept,
    output logic              win_last,
    output logic [DSEL_W-1:0] cur_dec
);
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        restart  = (dec_sel != cur_dec);
        accept   = smp_valid && !restart;
        win_last = accept && (cnt_q == last_index(cur_dec));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            cur_dec <= '0;
        end else if (restart) begin
            cnt_q   <= '0;
            cur_dec <= dec_sel;
        end else if (accept) begin
            cnt_q <= win_last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dec_accum.sv
module dec_accum
    import dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             accept,
    input  logic             win_last,
    input  logic [SMP_W-1:0] smp_data,
    output acc_t             sum_now
);
    acc_t acc_q;

    always_comb sum_now = acc_q + widen(smp_data);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            acc_q <= '0;
        end else if (accept) begin
            acc_q <= win_last ? '0 : sum_now;
        end
    end
endmodule

// File: rtl/dec_read_mux.sv
module dec_read_mux
    import dec_pkg::*;
(
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [SMP_W-1:0]  temp_data,
    input  result_t           res,
    output logic [SMP_W-1:0]  rd_data
);
    always_comb begin
        unique case (rd_addr)
            ADDR_TEMP: rd_data = temp_data;
            ADDR_EXT:  rd_data = res.ext_w;
            ADDR_MAIN: rd_data = res.main_w;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rate_decimator.sv
module rate_decimator
    import dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic [DSEL_W-1:0] dec_sel,
    input  logic [SMP_W-1:0]  temp_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [SMP_W-1:0]  rd_data,
    output logic              res_valid,
    output logic [SMP_W-1:0]  res_main,
    output logic [SMP_W-1:0]  res_ext
);
    logic              restart, accept, win_last;
    logic [DSEL_W-1:0] cur_dec;
    acc_t              sum_now;
    result_t           res_q, res_d;

    dec_window_ctrl u_ctrl (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .dec_sel(dec_sel),
        .restart(restart), .accept(accept), .win_last(win_last), .cur_dec(cur_dec)
    );

    dec_accum u_acc (
        .clk(clk), .rst(rst), .restart(restart), .accept(accept),
        .win_last(win_last), .smp_data(smp_data), .sum_now(sum_now)
    );

    always_comb res_d = split_sum(sum_now, cur_dec);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q     <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= win_last;
            if (win_last) res_q <= res_d;
        end
    end

    always_comb begin
        res_main = res_q.main_w;
        res_ext  = res_q.ext_w;
    end

    dec_read_mux u_rd (
        .rd_addr(rd_addr), .temp_data(temp_data), .res(res_q), .rd_data(rd_data)
    );
endmodule

// File: rtl/rate_decimator_chk.sv
module rate_decimator_chk
    import dec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              smp_valid,
    input logic [SMP_W-1:0]  smp_data,
    input logic [DSEL_W-1:0] dec_sel,
    input logic [SMP_W-1:0]  temp_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [SMP_W-1:0]  rd_data,
    input logic              res_valid,
    input logic [SMP_W-1:0]  res_main,
    input logic [SMP_W-1:0]  res_ext
);
    AST_RESULT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(smp_valid)); // R2

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> ($stable(res_main) && $stable(res_ext))); // R6

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(dec_sel) == '0) |-> (res_main == $past(smp_data) && res_ext == '0)); // R5

    AST_EXT_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(dec_sel) != '0 && $past(dec_sel) < 5'd16)
            |-> ((res_ext << $past(dec_sel)) == 16'h0000)); // R4

    AST_CHANGE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
        !$stable(dec_sel) |=> !res_valid); // R7

    AST_READ_MAIN: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_MAIN) |-> (rd_data == res_main)); // R8

    AST_READ_TEMP: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_TEMP) |-> (rd_data == temp_data)); // R8
endmodule

bind rate_decimator rate_decimator_chk u_chk (.*);

// File: tb/rate_decimator_tb_top.sv
module rate_decimator_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [4:0]  dec_sel = '0;
    logic [15:0] temp_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        res_valid;
    logic [15:0] res_main, res_ext;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    longint      m_acc = 0;
    longint      m_cnt = 0;
    int          m_dec = 0;
    logic [15:0] e_main = '0, e_ext = '0;
    logic        e_valid = 1'b0;

    always #2 clk = ~clk;

    rate_decimator dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .dec_sel(dec_sel), .temp_data(temp_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .res_valid(res_valid), .res_main(res_main), .res_ext(res_ext)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_main(input longint s, input int d);
        longint q;
        q = s >>> d;
        return q[15:0];
    endfunction

    function automatic logic [15:0] exp_ext(input longint s, input int d);
        longint r;
        if (d == 0) return 16'h0000;
        if (d <= 16) begin
            r = (s & ((64'sd1 <<< d) - 1)) <<< (16 - d);
            return r[15:0];
        end
        r = s >>> (d - 16);
        return r[15:0];
    endfunction

    // one clock: drive at negedge, update model, check after posedge
    task automatic step(input logic v, input logic [15:0] x, input logic [4:0] d, input string req);
        @(negedge clk);
        smp_valid = v; smp_data = x; dec_sel = d;
        e_valid = 1'b0;
        if (int'(d) != m_dec) begin
            m_dec = int'(d); m_acc = 0; m_cnt = 0;
        end else if (v) begin
            m_acc += longint'($signed(x));
            m_cnt++;
            if (m_cnt == (64'd1 << m_dec)) begin
                e_valid = 1'b1;
                e_main = exp_main(m_acc, m_dec);
                e_ext  = exp_ext(m_acc, m_dec);
                m_acc = 0; m_cnt = 0;
            end
        end
        @(posedge clk); #1;
        check({req, " R2 valid"}, {15'd0, res_valid}, {15'd0, e_valid});
        check({req, " R3 main"}, res_main, e_main);
        check({req, " R4 ext"}, res_ext, e_ext);
    endtask

    task automatic rand_phase(input int d, input int n, input int gap_pct, input string req);
        for (int i = 0; i < n; i++) begin
            logic v;
            v = (($urandom % 100) >= gap_pct);
            step(v, 16'($urandom), 5'(d), req);
        end
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd5171));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", {15'd0, res_valid}, 16'd0);
        check("R1 reset main", res_main, 16'h0000);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R1 after reset main", res_main, 16'h0000);
        check("R1 after reset ext", res_ext, 16'h0000);

        // R5 pass-through with D=0
        step(1'b1, 16'h0001, 5'd0, "R5");
        check("R5 plus one", res_main, 16'h0001);
        step(1'b1, 16'hFFFF, 5'd0, "R5");
        check("R5 minus one", res_main, 16'hFFFF);
        rand_phase(0, 30, 30, "R5");

        // directed D=3: 1,1,1,0,0,0,0,0 -> sum 3: main 0, ext 0x6000
        step(1'b0, 16'h0, 5'd3, "R7");
        for (int i = 0; i < 8; i++) step(1'b1, (i < 3) ? 16'h0001 : 16'h0000, 5'd3, "R4");
        check("R4 directed ext", res_ext, 16'h6000);
        check("R3 directed main", res_main, 16'h0000);

        // R9 extremes with D=4
        step(1'b0, 16'h0, 5'd4, "R7");
        for (int i = 0; i < 16; i++) step(1'b1, 16'h8000, 5'd4, "R9");
        check("R9 min main", res_main, 16'h8000);
        for (int i = 0; i < 16; i++) step(1'b1, 16'h7FFF, 5'd4, "R9");
        check("R9 max main", res_main, 16'h7FFF);
        check("R9 max ext", res_ext, 16'h0000);

        // random phases with several settings and gaps (R2, R3, R4, R6)
        for (int d = 1; d <= 7; d++) rand_phase(d, 300, 25, "R6");

        // mid-window setting changes (R7)
        for (int k = 0; k < 40; k++) begin
            rand_phase(int'($urandom % 6), int'($urandom % 20) + 1, 20, "R7");
        end
        rand_phase(2, 40, 10, "R7");

        // read decode (R8)
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            temp_data = 16'($urandom);
            rd_addr = (k % 4 == 3) ? 8'($urandom) : 8'(2 + 2 * (k % 4));
            #1;
            case (rd_addr)
                8'h02: check("R8 temp", rd_data, temp_data);
                8'h04: check("R8 ext", rd_data, res_ext);
                8'h06: check("R8 main", rd_data, res_main);
                default: check("R8 other", rd_data, 16'h0000);
            endcase
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule